// File: doc/BRIEF.md
# Interrupt Vector Relocation Unit

This block turns an acknowledged interrupt into the address the CPU fetches from next, and records which source was taken. Maskable and non-maskable acknowledges each arrive with a source code. In normal operation every source owns a 16-byte slot in a vector table held in flash. The slot address is the table base plus the source code times the slot size.

While flash is being reprogrammed from software, the flash table cannot be read. A relocation flag is then raised. In that state every maskable interrupt is sent to the first word of internal RAM, and every non-maskable interrupt is sent to the word after it. Software at those two shared entries reads the cause outputs to learn the real source. The cause outputs hold one field for maskable sources and one for non-maskable sources. Relocated vectoring takes one extra cycle, which software sees as added latency.

The flag is sampled in the cycle of the acknowledge. A request that is already on its way keeps the mode it started with.

Top module: `irq_vec_reloc`

## Requirements
- R1: A synchronous reset drives `vec_valid` low and clears both `cause_mi` and `cause_nmi` to zero.
- R2: With `reloc_en` low, a maskable acknowledge with code c raises `vec_valid` for one cycle in the cycle after the acknowledge, with `vec_addr` = FLASH_BASE + c*16.
- R3: With `reloc_en` low, a non-maskable acknowledge with code c gives the same timing and the same address formula as R2.
- R4: With `reloc_en` high, a maskable acknowledge leaves `vec_valid` low in the following cycle. In the cycle after that, `vec_valid` is high for one cycle with `vec_addr` = RAM_BASE.
- R5: With `reloc_en` high, a non-maskable acknowledge follows the R4 timing, with `vec_addr` = RAM_BASE + 4.
- R6: `vec_valid` is high for exactly one cycle per accepted acknowledge and stays low when no acknowledge is pending.
- R7: When `mi_ack` and `nmi_ack` are high in the same cycle, only the non-maskable request is vectored and recorded, and `cause_mi` keeps its value.
- R8: A maskable acknowledge that is not overridden loads its code into `cause_mi`, visible in the next cycle. Without an acknowledge, both cause fields hold their values.
- R9: A non-maskable acknowledge loads its code into `cause_nmi`, visible in the next cycle, and leaves `cause_mi` unchanged.
- R10: The address mode is the value of `reloc_en` in the acknowledge cycle. Changing `reloc_en` while a relocated request waits its extra cycle does not change that request's address or timing.
- R11: Acknowledges arrive with at least one idle cycle between them. Acknowledges in consecutive cycles are outside the block's operating range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reloc_en | input | 1 | Flash self-programming active: use the shared RAM entries |
| mi_ack | input | 1 | Maskable interrupt acknowledge |
| mi_code | input | CODE_W | Maskable source code |
| nmi_ack | input | 1 | Non-maskable interrupt acknowledge |
| nmi_code | input | CODE_W | Non-maskable source code |
| vec_valid | output | 1 | One-cycle strobe qualifying `vec_addr` |
| vec_addr | output | ADDR_W | Fetch address of the handler entry |
| cause_mi | output | CODE_W | Last recorded maskable source code |
| cause_nmi | output | CODE_W | Last recorded non-maskable source code |

## Verification
Every source code is acknowledged as maskable and as non-maskable in both modes. A wrong shift or base in the flash formula shows up in the normal-mode sweep, and any dependence on the code shows up in the relocated sweep, where the address must stay fixed. Simultaneous acknowledges show whether the precedence is right and whether the maskable cause field is protected. Toggling the flag during the extra cycle shows whether the mode is held per request or read live. Idle stretches and a reset in mid-run show that the cause fields hold their values and clear.

// File: rtl/irq_vec_reloc_pkg.sv
package irq_vec_reloc_pkg;

  typedef enum logic {
    SRC_MASKABLE = 1'b0,
    SRC_NMI      = 1'b1
  } src_kind_e;

  // Per-source slot in the flash-resident table.
  function automatic logic [63:0] flash_slot_addr(
    input logic [63:0] tbl_base,
    input logic [63:0] code,
    input int unsigned slot_shift
  );
    return tbl_base + (code << slot_shift);
  endfunction

  // Shared RAM entry: maskable at the base, non-maskable one word above.
  function automatic logic [63:0] ram_entry_addr(
    input logic [63:0] ram_base,
    input src_kind_e   kind,
    input int unsigned word_bytes
  );
    return (kind == SRC_NMI) ? ram_base + 64'(word_bytes) : ram_base;
  endfunction

endpackage

// File: rtl/ivr_arbiter.sv
module ivr_arbiter
  import irq_vec_reloc_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              mi_ack,
  input  logic [CODE_W-1:0] mi_code,
  input  logic              nmi_ack,
  input  logic [CODE_W-1:0] nmi_code,
  output logic              win_vld,
  output src_kind_e         win_kind,
  output logic [CODE_W-1:0] win_code
);

  // Non-maskable acknowledges take precedence over maskable ones.
  always_comb begin
    win_vld  = mi_ack | nmi_ack;
    win_kind = nmi_ack ? SRC_NMI : SRC_MASKABLE;
    win_code = nmi_ack ? nmi_code : mi_code;
  end

endmodule

// File: rtl/ivr_vector_calc.sv
module ivr_vector_calc
  import irq_vec_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CODE_W      = 8,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter logic [ADDR_W-1:0] RAM_BASE   = '0,
  parameter int unsigned ENTRY_BYTES = 16,
  parameter int unsigned WORD_BYTES  = 4
) (
  input  src_kind_e         kind,
  input  logic [CODE_W-1:0] code,
  input  logic              reloc,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned SLOT_SH = $clog2(ENTRY_BYTES);

  logic [63:0] flash_a;
  logic [63:0] ram_a;

  always_comb begin
    flash_a = flash_slot_addr(64'(FLASH_BASE), 64'(code), SLOT_SH);
    ram_a   = ram_entry_addr(64'(RAM_BASE), kind, WORD_BYTES);
    addr    = reloc ? ram_a[ADDR_W-1:0] : flash_a[ADDR_W-1:0];
  end

endmodule

// File: rtl/ivr_cause_reg.sv
module ivr_cause_reg
  import irq_vec_reloc_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_vld,
  input  src_kind_e         win_kind,
  input  logic [CODE_W-1:0] win_code,
  output logic [CODE_W-1:0] cause_mi,
  output logic [CODE_W-1:0] cause_nmi
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_mi  <= '0;
      cause_nmi <= '0;
    end else if (win_vld) begin
      if (win_kind == SRC_NMI) cause_nmi <= win_code;
      else                     cause_mi  <= win_code;
    end
  end

endmodule

// File: rtl/ivr_issue_pipe.sv
module ivr_issue_pipe #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic              req_reloc,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hold_vld,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);

  logic [ADDR_W-1:0] hold_addr;
  logic              go_now;
  logic              go_late;

  always_comb begin
    go_now  = req_vld & ~req_reloc;
    go_late = req_vld &  req_reloc;
  end

  // A relocated request waits in the hold stage for one extra cycle. Its
  // address is captured here, so a later flag change cannot affect it.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      hold_vld  <= go_late;
      if (go_late) hold_addr <= req_addr;
      vec_valid <= go_now | hold_vld;
      if (go_now)        vec_addr <= req_addr;
      else if (hold_vld) vec_addr <= hold_addr;
    end
  end

endmodule

// File: rtl/irq_vec_reloc.sv
module irq_vec_reloc
  import irq_vec_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CODE_W      = 8,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 'h0000_0100,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 'h3FF0_0000,
  parameter int unsigned ENTRY_BYTES = 16,
  parameter int unsigned WORD_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reloc_en,
  input  logic              mi_ack,
  input  logic [CODE_W-1:0] mi_code,
  input  logic              nmi_ack,
  input  logic [CODE_W-1:0] nmi_code,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [CODE_W-1:0] cause_mi,
  output logic [CODE_W-1:0] cause_nmi
);

  // Internal events, named so that the checker can observe them.
  logic              win_vld;
  src_kind_e         win_kind;
  logic [CODE_W-1:0] win_code;
  logic [ADDR_W-1:0] win_addr;
  logic              hold_vld;

  ivr_arbiter #(.CODE_W(CODE_W)) u_arb (
    .mi_ack   (mi_ack),
    .mi_code  (mi_code),
    .nmi_ack  (nmi_ack),
    .nmi_code (nmi_code),
    .win_vld  (win_vld),
    .win_kind (win_kind),
    .win_code (win_code)
  );

  ivr_vector_calc #(
    .ADDR_W      (ADDR_W),
    .CODE_W      (CODE_W),
    .FLASH_BASE  (FLASH_BASE),
    .RAM_BASE    (RAM_BASE),
    .ENTRY_BYTES (ENTRY_BYTES),
    .WORD_BYTES  (WORD_BYTES)
  ) u_calc (
    .kind  (win_kind),
    .code  (win_code),
    .reloc (reloc_en),
    .addr  (win_addr)
  );

  ivr_cause_reg #(.CODE_W(CODE_W)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .win_vld   (win_vld),
    .win_kind  (win_kind),
    .win_code  (win_code),
    .cause_mi  (cause_mi),
    .cause_nmi (cause_nmi)
  );

  ivr_issue_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (win_vld),
    .req_reloc (reloc_en),
    .req_addr  (win_addr),
    .hold_vld  (hold_vld),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr)
  );

endmodule

// File: rtl/irq_vec_reloc_chk.sv
module irq_vec_reloc_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CODE_W      = 8,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter logic [ADDR_W-1:0] RAM_BASE   = '0,
  parameter int unsigned ENTRY_BYTES = 16,
  parameter int unsigned WORD_BYTES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reloc_en,
  input logic              mi_ack,
  input logic [CODE_W-1:0] mi_code,
  input logic              nmi_ack,
  input logic [CODE_W-1:0] nmi_code,
  input logic              vec_valid,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [CODE_W-1:0] cause_mi,
  input logic [CODE_W-1:0] cause_nmi,
  input logic              hold_vld
);

  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] NMI_RAM = RAM_BASE + ADDR_W'(WORD_BYTES);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vec_valid && cause_mi == '0 && cause_nmi == '0));

  a_r2_flash_maskable: assert property (@(posedge clk) disable iff (rst)
    (mi_ack && !nmi_ack && !reloc_en) |=>
      (vec_valid && vec_addr == FLASH_BASE + ADDR_W'($past(mi_code)) * SLOT));

  a_r3_flash_nmi: assert property (@(posedge clk) disable iff (rst)
    (nmi_ack && !reloc_en) |=>
      (vec_valid && vec_addr == FLASH_BASE + ADDR_W'($past(nmi_code)) * SLOT));

  a_r4_ram_maskable: assert property (@(posedge clk) disable iff (rst)
    (mi_ack && !nmi_ack && reloc_en) |=>
      !vec_valid ##1 (vec_valid && vec_addr == RAM_BASE));

  a_r5_ram_nmi: assert property (@(posedge clk) disable iff (rst)
    (nmi_ack && reloc_en) |=> !vec_valid ##1 (vec_valid && vec_addr == NMI_RAM));

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!mi_ack && !nmi_ack && !hold_vld) |=> !vec_valid);

  a_r7_nmi_precedence: assert property (@(posedge clk) disable iff (rst)
    (mi_ack && nmi_ack) |=> $stable(cause_mi));

  a_r8_cause_hold: assert property (@(posedge clk) disable iff (rst)
    (!mi_ack && !nmi_ack) |=> ($stable(cause_mi) && $stable(cause_nmi)));

  a_r8_cause_mi_load: assert property (@(posedge clk) disable iff (rst)
    (mi_ack && !nmi_ack) |=> (cause_mi == $past(mi_code) && $stable(cause_nmi)));

  a_r9_cause_nmi_load: assert property (@(posedge clk) disable iff (rst)
    nmi_ack |=> cause_nmi == $past(nmi_code));

  a_r10_held_mode: assert property (@(posedge clk) disable iff (rst)
    hold_vld |=> vec_valid);

  a_r11_ack_spacing: assert property (@(posedge clk) disable iff (rst)
    (mi_ack || nmi_ack) |=> !(mi_ack || nmi_ack));

endmodule

bind irq_vec_reloc irq_vec_reloc_chk #(
  .ADDR_W      (ADDR_W),
  .CODE_W      (CODE_W),
  .FLASH_BASE  (FLASH_BASE),
  .RAM_BASE    (RAM_BASE),
  .ENTRY_BYTES (ENTRY_BYTES),
  .WORD_BYTES  (WORD_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reloc_en  (reloc_en),
  .mi_ack    (mi_ack),
  .mi_code   (mi_code),
  .nmi_ack   (nmi_ack),
  .nmi_code  (nmi_code),
  .vec_valid (vec_valid),
  .vec_addr  (vec_addr),
  .cause_mi  (cause_mi),
  .cause_nmi (cause_nmi),
  .hold_vld  (hold_vld)
);

// File: tb/irq_vec_reloc_bench.sv
module irq_vec_reloc_bench;

  localparam int unsigned AW = 32;
  localparam int unsigned CW = 8;
  localparam logic [31:0] FBASE = 32'h0000_0100;
  localparam logic [31:0] RBASE = 32'h3FF0_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reloc_en = 1'b0;
  logic          mi_ack = 1'b0;
  logic [CW-1:0] mi_code = '0;
  logic          nmi_ack = 1'b0;
  logic [CW-1:0] nmi_code = '0;
  logic          vec_valid;
  logic [AW-1:0] vec_addr;
  logic [CW-1:0] cause_mi;
  logic [CW-1:0] cause_nmi;

  int n_chk = 0;
  int n_bad = 0;
  logic [CW-1:0] exp_cmi = '0;
  logic [CW-1:0] exp_cnmi = '0;

  always #5 clk = ~clk;

  irq_vec_reloc #(
    .ADDR_W (AW), .CODE_W (CW), .FLASH_BASE (FBASE), .RAM_BASE (RBASE),
    .ENTRY_BYTES (16), .WORD_BYTES (4)
  ) u_irq_vec_reloc (
    .clk (clk), .rst (rst), .reloc_en (reloc_en),
    .mi_ack (mi_ack), .mi_code (mi_code),
    .nmi_ack (nmi_ack), .nmi_code (nmi_code),
    .vec_valid (vec_valid), .vec_addr (vec_addr),
    .cause_mi (cause_mi), .cause_nmi (cause_nmi)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_causes(input string tag);
    chk({tag, " cause_mi"}, longint'(cause_mi), longint'(exp_cmi));
    chk({tag, " cause_nmi"}, longint'(cause_nmi), longint'(exp_cnmi));
  endtask

  // One acknowledge; samples are taken at falling edges.
  task automatic ack_once(input bit do_mi, input bit do_nmi,
                          input logic [CW-1:0] cm, input logic [CW-1:0] cn,
                          input bit m, input bit flip_mid, input string tag);
    longint exp_a;
    @(negedge clk);
    reloc_en = m; mi_ack = do_mi; mi_code = cm; nmi_ack = do_nmi; nmi_code = cn;
    if (m) exp_a = longint'(RBASE) + (do_nmi ? 4 : 0);
    else   exp_a = longint'(FBASE) + 16 * longint'(do_nmi ? cn : cm);
    if (do_nmi)     exp_cnmi = cn;
    else if (do_mi) exp_cmi  = cm;
    @(negedge clk);
    mi_ack = 1'b0; nmi_ack = 1'b0;
    if (flip_mid) reloc_en = ~m;
    chk_causes(tag);
    if (!m) begin
      chk({tag, " valid"}, longint'(vec_valid), 1);
      chk({tag, " addr"}, longint'(vec_addr), exp_a);
    end else begin
      chk({tag, " valid early"}, longint'(vec_valid), 0);
    end
    @(negedge clk);
    if (m) begin
      chk({tag, " valid"}, longint'(vec_valid), 1);
      chk({tag, " addr"}, longint'(vec_addr), exp_a);
    end else begin
      chk({tag, " R6 pulse"}, longint'(vec_valid), 0);
    end
    @(negedge clk);
    chk({tag, " R6 idle"}, longint'(vec_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", longint'(vec_valid), 0);
    chk_causes("R1");
    rst = 1'b0;

    // R2 R3 R4 R5 R8 R9: sweep every code in both modes
    for (int c = 0; c < 256; c++) begin
      for (int m = 0; m < 2; m++) begin
        ack_once(1'b1, 1'b0, CW'(c), '0, m[0], 1'b0, m ? "R4" : "R2");
        ack_once(1'b0, 1'b1, '0, CW'(c) ^ 8'hA5, m[0], 1'b0, m ? "R5" : "R3");
      end
    end

    // R7 simultaneous acknowledges in both modes
    ack_once(1'b1, 1'b0, 8'h3C, '0, 1'b0, 1'b0, "R8 setup");
    ack_once(1'b1, 1'b1, 8'h11, 8'h77, 1'b0, 1'b0, "R7 normal");
    ack_once(1'b1, 1'b1, 8'h22, 8'h99, 1'b1, 1'b0, "R7 reloc");

    // R10 flag change while a request is in flight
    ack_once(1'b1, 1'b0, 8'h40, '0, 1'b1, 1'b1, "R10 mi");
    ack_once(1'b0, 1'b1, '0, 8'h41, 1'b1, 1'b1, "R10 nmi");
    ack_once(1'b1, 1'b0, 8'h42, '0, 1'b0, 1'b1, "R10 normal");

    // R8 causes hold and no strobe while idle
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reloc_en = i[0];
      chk("R6 idle strobe", longint'(vec_valid), 0);
      chk_causes("R8 hold");
    end

    // R1 reset in mid-run clears causes
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_cmi = '0; exp_cnmi = '0;
    chk("R1 valid after reset", longint'(vec_valid), 0);
    chk_causes("R1 mid-run");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R1..R11 not reached): got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule